// File: doc/BRIEF.md
# Lockable Write-Protect Window for Physical Memory

This block sits in the write path of a memory controller and guards one contiguous physical region against modification. Software programs a lower and an upper bound, both as page indices counted from a fixed physical memory base, and then engages a one-way lock. From then on, every write request whose page falls inside the window gets a reject verdict. The bounds and the lock stay frozen until the next reset.

Each request carries an address, a direction flag and a valid strobe. The block answers every valid request with a registered verdict one cycle later. Read requests are never rejected. Before the lock is engaged, all requests pass, which leaves time for one-time initialisation of the contents that are later protected. A small register port lets software write the bounds and the lock and read back their current values.

Top module: `rom_region_guard`

## Requirements
- R1: After reset the lower bound, the upper bound and the lock read back as zero, and `rsp_valid` is low.
- R2: While unlocked, a register write with `cfg_sel` = 0 loads the lower bound page and `cfg_sel` = 1 loads the upper bound page. `cfg_rdata` returns the selected value combinationally, and `cfg_sel` = 2 returns the lock state in bit 0.
- R3: While unlocked, a register write with `cfg_sel` = 2 and bit 0 of `cfg_wdata` set engages the lock. A write with bit 0 clear leaves it disengaged. Once engaged, the lock stays engaged until reset.
- R4: While locked, register writes to either bound or to the lock leave all read-back values unchanged.
- R5: Each cycle with `req_valid` high produces exactly one cycle with `rsp_valid` high in the following cycle, and no response appears without a request.
- R6: While locked, a write request is rejected (`rsp_block` = 1) when its page index, (address − PHYS_BASE) >> 14 (16 KiB pages), is at least the lower bound and strictly below the upper bound. This holds at any offset within the page.
- R7: While locked, a write request passes when its page index equals or exceeds the upper bound, when its page index is below the lower bound, or when its address is below PHYS_BASE.
- R8: Read requests (`req_write` = 0) always pass.
- R9: While unlocked, no request is rejected, whatever its address.
- R10: When the upper bound is not greater than the lower bound, no request is rejected, even when the lock is engaged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the only way to clear the lock |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 lower bound, 1 upper bound, 2 lock |
| cfg_wdata | input | PAGE_W (26) | Register write data in page units; bit 0 is used for the lock |
| cfg_rdata | output | PAGE_W (26) | Read-back of the selected register |
| req_valid | input | 1 | Memory request strobe |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | ADDR_W (40) | Physical byte address of the request |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_block | output | 1 | 1 when the request is rejected |

## Verification
Several rules are checked by the assertions on every cycle: the lock stays set once set, the bounds stay frozen while locked, one response follows each request, and reads, unlocked traffic and empty or inverted windows never produce a reject. The bench scenarios cover the behaviour that depends on where a request lands relative to the window. These cases are the first and last protected page, the page just past the upper bound, addresses below the physical base, and register writes before and after the lock. They also cover reset releasing the lock.

// File: rtl/rrg_pkg.sv
package rrg_pkg;

    // Register selector encoding seen on cfg_sel
    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LOCK = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Registered verdict returned for each request
    typedef struct packed {
        logic valid;
        logic block;
    } verdict_t;

    // Page index lies inside the half-open window [lo, hi)
    function automatic logic in_window(input logic [63:0] page,
                                       input logic [63:0] lo,
                                       input logic [63:0] hi);
        return (page >= lo) && (page < hi);
    endfunction

endpackage

// File: rtl/rrg_page_map.sv
module rrg_page_map #(
    parameter int unsigned ADDR_W     = 40,
    parameter int unsigned PAGE_SHIFT = 14,
    parameter logic [63:0] PHYS_BASE  = 64'h0000_0008_0000_0000,
    localparam int unsigned PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PAGE_W-1:0] page_idx,
    output logic              below_base
);
    localparam logic [ADDR_W-1:0] BASE_A = PHYS_BASE[ADDR_W-1:0];

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel        = addr - BASE_A;
        below_base = (addr < BASE_A);
        page_idx   = PAGE_W'(rel >> PAGE_SHIFT);
    end
endmodule

// File: rtl/rrg_regs.sv
module rrg_regs
    import rrg_pkg::*;
#(
    parameter int unsigned PAGE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [PAGE_W-1:0] cfg_wdata,
    output logic [PAGE_W-1:0] cfg_rdata,
    output logic [PAGE_W-1:0] lo_page,
    output logic [PAGE_W-1:0] hi_page,
    output logic              locked
);
    logic [PAGE_W-1:0] lo_q, hi_q;
    logic              lock_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            lock_q <= 1'b0;
        end else if (cfg_we && !lock_q) begin
            case (sel)
                SEL_LO:   lo_q <= cfg_wdata;
                SEL_HI:   hi_q <= cfg_wdata;
                SEL_LOCK: if (cfg_wdata[0]) lock_q <= 1'b1;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_LO:   cfg_rdata = lo_q;
            SEL_HI:   cfg_rdata = hi_q;
            SEL_LOCK: cfg_rdata = {{(PAGE_W-1){1'b0}}, lock_q};
            default:  cfg_rdata = '0;
        endcase
    end

    assign lo_page = lo_q;
    assign hi_page = hi_q;
    assign locked  = lock_q;

    // R3: the lock never drops without reset
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    // R4: bounds frozen while locked, even under register writes
    a_r4_bounds_frozen: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/rrg_decide.sv
module rrg_decide
    import rrg_pkg::*;
#(
    parameter int unsigned PAGE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [PAGE_W-1:0] page_idx,
    input  logic              below_base,
    input  logic [PAGE_W-1:0] lo_page,
    input  logic [PAGE_W-1:0] hi_page,
    input  logic              locked,
    output verdict_t          verdict
);
    logic     hit;
    verdict_t next_v;

    always_comb begin
        hit = !below_base &&
              in_window(64'(page_idx), 64'(lo_page), 64'(hi_page));
        next_v.valid = req_valid;
        next_v.block = req_valid && req_write && locked && hit;
    end

    always_ff @(posedge clk) begin
        if (rst) verdict <= '0;
        else     verdict <= next_v;
    end

    // R5: one response per request, one cycle later
    a_r5_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> verdict.valid);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !verdict.valid);

    // R8: reads pass
    a_r8_read_pass: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> !verdict.block);

    // R9: nothing blocked before lock
    a_r9_unlocked_pass: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !locked) |=> !verdict.block);

    // R10: empty or inverted window protects nothing
    a_r10_empty_window: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (hi_page <= lo_page)) |=> !verdict.block);
endmodule

// File: rtl/rom_region_guard.sv
module rom_region_guard
    import rrg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 40,
    parameter int unsigned PAGE_SHIFT = 14,
    parameter logic [63:0] PHYS_BASE  = 64'h0000_0008_0000_0000,
    localparam int unsigned PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [PAGE_W-1:0] cfg_wdata,
    output logic [PAGE_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_block
);
    logic [PAGE_W-1:0] page_idx, lo_page, hi_page;
    logic              below_base, locked;
    verdict_t          verdict;

    rrg_page_map #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PHYS_BASE(PHYS_BASE)
    ) u_map (
        .addr(req_addr), .page_idx(page_idx), .below_base(below_base)
    );

    rrg_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lo_page(lo_page), .hi_page(hi_page), .locked(locked)
    );

    rrg_decide #(.PAGE_W(PAGE_W)) u_decide (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .page_idx(page_idx), .below_base(below_base),
        .lo_page(lo_page), .hi_page(hi_page), .locked(locked),
        .verdict(verdict)
    );

    assign rsp_valid = verdict.valid;
    assign rsp_block = verdict.block;

    // R1: no response in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !rsp_valid);
endmodule

// File: tb/rom_region_guard_tb.sv
module rom_region_guard_tb;
    localparam int unsigned ADDR_W = 40;
    localparam int unsigned PSH    = 14;
    localparam int unsigned PAGE_W = ADDR_W - PSH;
    localparam logic [ADDR_W-1:0] PB = 40'h08_0000_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = 2'd0;
    logic [PAGE_W-1:0] cfg_wdata = '0;
    logic [PAGE_W-1:0] cfg_rdata;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid, rsp_block;

    always #4 clk = ~clk;

    rom_region_guard u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_block(rsp_block)
    );

    typedef struct {
        logic              blk;
        string             tag;
        logic [ADDR_W-1:0] addr;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   pushed = 0;
    int   popped = 0;
    bit   done   = 1'b0;

    // bench model of the register state
    logic [PAGE_W-1:0] m_lo, m_hi;
    logic              m_lock;

    function automatic logic expect_block(input logic [ADDR_W-1:0] a, input logic wr);
        logic [ADDR_W-1:0] pg;
        if (!wr || !m_lock || a < PB) return 1'b0;
        pg = (a - PB) / (ADDR_W'(1) << PSH);
        return (pg >= ADDR_W'(m_lo)) && (pg < ADDR_W'(m_hi));
    endfunction

    function automatic logic [ADDR_W-1:0] pa(input int unsigned page, input int unsigned off);
        return PB + (ADDR_W'(page) << PSH) + ADDR_W'(off);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_lo = '0; m_hi = '0; m_lock = 1'b0;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [PAGE_W-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!m_lock) begin
            case (sel)
                2'd0: m_lo = val;
                2'd1: m_hi = val;
                2'd2: if (val[0]) m_lock = 1'b1;
                default: ;
            endcase
        end
    endtask

    task automatic cfg_check(input string tag, input logic [1:0] sel, input logic [PAGE_W-1:0] exp);
        cfg_sel = sel;
        #1;
        check(tag, 64'(cfg_rdata), 64'(exp));
    endtask

    // driver: issue one request per cycle, push expected verdict
    task automatic send(input string tag, input logic [ADDR_W-1:0] a, input logic wr);
        exp_t e;
        req_valid = 1'b1; req_write = wr; req_addr = a;
        e.blk = expect_block(a, wr); e.tag = tag; e.addr = a;
        exp_q.push_back(e);
        pushed++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare verdicts as they emerge
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5: actual response without request expected none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                popped++;
                check($sformatf("%s addr %0h", e.tag, e.addr), 64'(rsp_block), 64'(e.blk));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_lo = '0; m_hi = '0; m_lock = 1'b0;
        do_reset();

        // R1 reset state
        #1 check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        cfg_check("R1 lo", 2'd0, '0);
        cfg_check("R1 hi", 2'd1, '0);
        cfg_check("R1 lock", 2'd2, '0);

        // R2 program and read back
        cfg_write(2'd0, 26'd4);
        cfg_write(2'd1, 26'd10);
        cfg_check("R2 lo", 2'd0, 26'd4);
        cfg_check("R2 hi", 2'd1, 26'd10);

        // R9 unlocked: writes inside window pass; R8 read
        send("R9 unlocked write", pa(5, 0), 1'b1);
        send("R9 unlocked write", pa(9, 16'h3FFF), 1'b1);
        send("R8 unlocked read", pa(6, 8), 1'b0);
        idle(1);
        // R5 no response in an idle cycle
        check("R5 idle rsp_valid", 64'(rsp_valid), 64'd0);

        // R3 writing 0 to lock has no effect
        cfg_write(2'd2, 26'd0);
        cfg_check("R3 lock stays clear", 2'd2, 26'd0);

        // R2 re-program, then lock
        cfg_write(2'd0, 26'd5);
        cfg_write(2'd1, 26'd9);
        cfg_check("R2 lo reprog", 2'd0, 26'd5);
        cfg_check("R2 hi reprog", 2'd1, 26'd9);
        cfg_write(2'd2, 26'd1);
        cfg_check("R3 lock set", 2'd2, 26'd1);

        // R4 locked register writes ignored
        cfg_write(2'd0, 26'd0);
        cfg_write(2'd1, 26'd1000);
        cfg_write(2'd2, 26'd0);
        cfg_check("R4 lo frozen", 2'd0, 26'd5);
        cfg_check("R4 hi frozen", 2'd1, 26'd9);
        cfg_check("R4 lock held", 2'd2, 26'd1);

        // R6 / R7 / R8 locked traffic, back to back
        send("R6 first page", pa(5, 0), 1'b1);
        send("R6 last page end", pa(8, 16'h3FFF), 1'b1);
        send("R6 mid page", pa(7, 16'h1234), 1'b1);
        send("R7 hi page", pa(9, 0), 1'b1);
        send("R7 below lo", pa(4, 16'h3FFF), 1'b1);
        send("R7 below base", PB - 40'd1, 1'b1);
        send("R7 far above", pa(100000, 0), 1'b1);
        send("R8 locked read", pa(6, 0), 1'b0);
        idle(2);
        check("R5 all answered", 64'(popped), 64'(pushed));

        // R10 empty window (hi == lo), locked
        do_reset();
        cfg_check("R1 lock cleared by reset", 2'd2, '0);
        cfg_write(2'd0, 26'd7);
        cfg_write(2'd1, 26'd7);
        cfg_write(2'd2, 26'd1);
        send("R10 equal bounds", pa(7, 0), 1'b1);
        send("R10 equal bounds", pa(6, 0), 1'b1);
        idle(2);

        // R10 inverted window
        do_reset();
        cfg_write(2'd0, 26'd9);
        cfg_write(2'd1, 26'd3);
        cfg_write(2'd2, 26'd1);
        send("R10 inverted", pa(5, 0), 1'b1);
        send("R10 inverted", pa(9, 0), 1'b1);
        idle(2);
        check("R5 final count", 64'(popped), 64'(pushed));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule